// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets software reach the management registers of an external Ethernet PHY over the two-wire MDC/MDIO bus using Clause 22 framing. Software sets up the MDC divider and turns the engine on through a control word. It then writes one command word. That word holds a self-clearing go flag, a read/write selector, the PHY address, the register number and, for writes, the data to send.

While the go flag is set, the engine produces MDC from the bus clock and shifts out the full 64-bit management frame. On a read it releases MDIO for the turnaround and the data phase. It samples the PHY's acknowledge and the 16 returned bits, and leaves the result in the same command word. Software polls the go flag, or the idle bit of the control word, to learn that the access has finished.

Each acknowledged read marks its PHY address in a 32-bit alive map. If the fault reporting option is switched on, an unacknowledged read raises a sticky fault flag.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle bit 31 set, engine off, divider 0), and the command word and alive map read 0. MDC is low and MDIO is not driven.
- R2: While enabled, MDC has a period of divider+1 bus clocks. The divider sits in control bits 7:0, and divider values 0 and 1 both give a period of 2. While disabled, MDC stays low.
- R3: A write frame is 32 ones, then 01, then 01, then the 5-bit PHY address, the 5-bit register number, 10 and the 16 data bits, each sent MSB first. MDIO is driven for all 64 bits, and the driven value changes only when MDC falls.
- R4: A read frame drives 32 ones, 01, 10, the PHY address and the register number. It releases MDIO for the last 18 bits and samples MDIO when MDC rises. A low level in the second turnaround bit counts as the acknowledge.
- R5: The command word has go in bit 31, write-select (1 = write) in bit 30, acknowledge in bit 29, register number in 25:21, PHY address in 20:16 and data in 15:0. Writing it with go set starts an access only while the enable bit (control bit 30) is set. Go stays set until the frame ends and then clears itself, and control bit 31 (idle) reads as the inverse of go.
- R6: A write to the command word while go is set leaves the whole command word unchanged.
- R7: When a read ends, bit 29 holds the acknowledge. Bits 15:0 hold the received data if the read was acknowledged and 0xFFFF if it was not.
- R8: The alive map (word address 2) sets the bit of a PHY address when a read to that address is acknowledged. No bit ever clears except by reset.
- R9: With fault-enable (control bit 18) set, an unacknowledged read sets the fault flag (control bit 19). Writing the control word with bit 19 set clears it.
- R10: The control word reads back its divider, enable and fault-enable fields as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word select: 0 control, 1 command, 2 alive map |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
The hardest case to reach from the ports is a command write that arrives while a frame is still being shifted. The stimulus issues a second command in the middle of a read, between two MDC rising edges. It then checks that the captured frame, the returned data and the read-back PHY and register fields all belong to the first command. A second hard case is a go flag that waits while the engine is off: a command is written with the engine disabled, MDIO is confirmed idle, and only then is the engine enabled. An unacknowledged read with fault reporting on covers the all-ones data path and the sticky fault flag.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_AW      = 5;
    localparam int PHY_N       = 1 << PHY_AW;
    localparam int FRAME_BITS  = 64;
    localparam int TA_FIRST    = 46;
    localparam int ACK_POS     = 47;
    localparam int DATA_FIRST  = 48;
    localparam int CNT_W       = $clog2(FRAME_BITS);

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CMD   = 2'd1;
    localparam logic [1:0] ADDR_ALIVE = 2'd2;

    localparam int CTRL_IDLE  = 31;
    localparam int CTRL_EN    = 30;
    localparam int CTRL_FAULT = 19;
    localparam int CTRL_FEN   = 18;

    typedef struct packed {
        logic              go;
        logic              wr;
        logic              ack;
        logic [2:0]        rsv;
        logic [PHY_AW-1:0] regad;
        logic [PHY_AW-1:0] phy;
        logic [15:0]       data;
    } cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              is_wr,
        input logic [PHY_AW-1:0] phy,
        input logic [PHY_AW-1:0] regad,
        input logic [15:0]       data
    );
        return {32'hFFFF_FFFF, 2'b01, (is_wr ? 2'b01 : 2'b10), phy, regad,
                (is_wr ? 2'b10 : 2'b11), (is_wr ? data : 16'hFFFF)};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             fall_ev,
    output logic             rise_ev
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;
    logic [DIV_W:0]   half;
    logic [DIV_W:0]   cnt_nxt;

    always_comb begin
        eff     = (div == '0) ? DIV_W'(1) : div;
        half    = ({1'b0, eff} + 1'b1) >> 1;
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
        fall_ev = en && (cnt_q >= eff);
        rise_ev = en && !fall_ev && (cnt_nxt == half);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (fall_ev) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt[DIV_W-1:0];
            if (rise_ev) mdc <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic              start,
    input  logic              is_wr,
    input  logic [PHY_AW-1:0] phy,
    input  logic [PHY_AW-1:0] regad,
    input  logic [15:0]       wdata,
    input  logic              mdio_in,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [15:0]       rdata,
    output logic              mdio_out,
    output logic              mdio_oe
);
    logic [FRAME_BITS-1:0] frame_q;
    logic [CNT_W-1:0]      bit_q;
    logic [CNT_W-1:0]      nidx;
    logic                  started_q;
    logic                  wr_q;

    assign nidx = bit_q + 1'b1;
    assign done = busy && started_q && fall_ev && (bit_q == CNT_W'(FRAME_BITS-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            started_q <= 1'b0;
            bit_q     <= '0;
            frame_q   <= '0;
            wr_q      <= 1'b0;
            ack       <= 1'b0;
            rdata     <= '0;
            mdio_out  <= 1'b1;
            mdio_oe   <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy      <= 1'b1;
                started_q <= 1'b0;
                bit_q     <= '0;
                wr_q      <= is_wr;
                ack       <= 1'b0;
                frame_q   <= build_frame(is_wr, phy, regad, wdata);
            end
        end else if (fall_ev) begin
            if (!started_q) begin
                started_q <= 1'b1;
                mdio_out  <= frame_q[FRAME_BITS-1];
                mdio_oe   <= 1'b1;
            end else if (done) begin
                busy      <= 1'b0;
                started_q <= 1'b0;
                mdio_out  <= 1'b1;
                mdio_oe   <= 1'b0;
            end else begin
                bit_q    <= nidx;
                mdio_out <= frame_q[CNT_W'(FRAME_BITS-1) - nidx];
                mdio_oe  <= wr_q || (nidx < CNT_W'(TA_FIRST));
            end
        end else if (rise_ev && started_q && !wr_q) begin
            if (bit_q == CNT_W'(ACK_POS))
                ack <= !mdio_in;
            else if (bit_q >= CNT_W'(DATA_FIRST))
                rdata <= {rdata[14:0], mdio_in};
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    cmd_t             cmd_q;
    logic [DIV_W-1:0] div_q;
    logic             en_q;
    logic             fault_q;
    logic             fen_q;
    logic [PHY_N-1:0] alive_q;

    logic        fall_ev, rise_ev;
    logic        sh_busy, sh_done, sh_ack, sh_start;
    logic [15:0] sh_rdata;
    logic        wr_ctrl, wr_cmd;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_cmd   = bus_wr && (bus_addr == ADDR_CMD) && !cmd_q.go;
    assign sh_start = cmd_q.go && en_q && !sh_busy;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .en(en_q), .div(div_q),
        .mdc(mdc), .fall_ev(fall_ev), .rise_ev(rise_ev)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst(rst), .fall_ev(fall_ev), .rise_ev(rise_ev),
        .start(sh_start), .is_wr(cmd_q.wr), .phy(cmd_q.phy),
        .regad(cmd_q.regad), .wdata(cmd_q.data), .mdio_in(mdio_in),
        .busy(sh_busy), .done(sh_done), .ack(sh_ack), .rdata(sh_rdata),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            div_q   <= '0;
            en_q    <= 1'b0;
            fault_q <= 1'b0;
            fen_q   <= 1'b0;
            alive_q <= '0;
        end else begin
            if (wr_ctrl) begin
                div_q <= bus_wdata[DIV_W-1:0];
                en_q  <= bus_wdata[CTRL_EN];
                fen_q <= bus_wdata[CTRL_FEN];
                if (bus_wdata[CTRL_FAULT]) fault_q <= 1'b0;
            end
            if (wr_cmd) begin
                cmd_q     <= cmd_t'(bus_wdata);
                cmd_q.ack <= 1'b0;
                cmd_q.rsv <= '0;
            end
            if (sh_done) begin
                cmd_q.go <= 1'b0;
                if (cmd_q.wr) begin
                    cmd_q.ack <= 1'b0;
                end else begin
                    cmd_q.ack  <= sh_ack;
                    cmd_q.data <= sh_ack ? sh_rdata : 16'hFFFF;
                    if (sh_ack) alive_q[cmd_q.phy] <= 1'b1;
                    else if (fen_q) fault_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_IDLE]  = !cmd_q.go;
                bus_rdata[CTRL_EN]    = en_q;
                bus_rdata[CTRL_FAULT] = fault_q;
                bus_rdata[CTRL_FEN]   = fen_q;
                bus_rdata[DIV_W-1:0]  = div_q;
            end
            ADDR_CMD:   bus_rdata = cmd_q;
            ADDR_ALIVE: bus_rdata = alive_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              go,
    input logic              cmd_wr,
    input logic [PHY_AW-1:0] cmd_phy,
    input logic [PHY_AW-1:0] cmd_reg,
    input logic [15:0]       cmd_data,
    input logic              en,
    input logic              fen,
    input logic              fault,
    input logic              done,
    input logic              ack,
    input logic [PHY_N-1:0]  alive,
    input logic              mdc,
    input logic              mdio_out,
    input logic              mdio_oe
);
    // R2: MDC held low while the engine is off
    a_r2_mdc_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mdc);

    // R3: MDIO value changes only together with a falling MDC
    a_r3_drive_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_out) |-> $fell(mdc));

    // R5: MDIO is never driven once go has cleared
    a_r5_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        !go |-> !mdio_oe);

    // R6: a command write during an access leaves the command fields alone
    a_r6_cmd_locked: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_CMD && go && !done)
        |=> ($stable(cmd_phy) && $stable(cmd_reg) && $stable(cmd_wr) && go));

    // R7: an unacknowledged read leaves all ones in the data field
    a_r7_nack_ones: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_wr && !ack) |=> (cmd_data == 16'hFFFF));

    // R8: alive bits never clear
    a_r8_alive_sticky: assert property (@(posedge clk) disable iff (rst)
        (alive & $past(alive)) == $past(alive));

    // R9: unacknowledged read with fault reporting on raises the fault flag
    a_r9_fault_set: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_wr && !ack && fen) |=> fault);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .go(cmd_q.go), .cmd_wr(cmd_q.wr), .cmd_phy(cmd_q.phy),
    .cmd_reg(cmd_q.regad), .cmd_data(cmd_q.data), .en(en_q), .fen(fen_q),
    .fault(fault_q), .done(sh_done), .ack(sh_ack), .alive(alive_q),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [31:0] last_cmd;
    logic [31:0] exp_alive = '0;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // {write, responds, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [27:0] VEC [6] = '{
        {1'b1, 1'b0, 5'd3,  5'd0,  16'hA5C3},
        {1'b0, 1'b1, 5'd3,  5'd1,  16'h796D},
        {1'b0, 1'b0, 5'd9,  5'd2,  16'h1234},
        {1'b1, 1'b0, 5'd31, 5'd31, 16'h0001},
        {1'b0, 1'b1, 5'd0,  5'd31, 16'h8000},
        {1'b0, 1'b1, 5'd31, 5'd4,  16'hFFFE}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic run_txn(input logic do_wr, input logic wr, input logic resp,
                           input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] dat, input logic poke);
        logic [63:0] cap_o, cap_e, exp_f, exp_e;
        logic [31:0] r;
        if (do_wr) bus_write(2'd1, {1'b1, wr, 1'b0, 3'b0, rg, phy, dat});
        mdio_in = 1'b1;
        @(posedge mdio_oe);
        for (int k = 0; k < 64; k++) begin
            int nb;
            @(posedge mdc);
            cap_o[63-k] = mdio_out;
            cap_e[63-k] = mdio_oe;
            nb = k + 1;
            if (!wr && resp && nb == 47) mdio_in = 1'b0;
            else if (!wr && resp && nb >= 48 && nb < 64) mdio_in = dat[63-nb];
            else mdio_in = 1'b1;
            if (poke && k == 10) bus_write(2'd1, 32'hC3FF_FFFF);
        end
        r = '1;
        for (int t = 0; t < 50; t++) begin
            bus_read(2'd1, r);
            if (!r[31]) break;
        end
        mdio_in = 1'b1;
        last_cmd = r;
        exp_f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, dat};
        exp_e = wr ? '1 : 64'hFFFF_FFFF_FFFC_0000;
        check((cap_o & exp_e) == (exp_f & exp_e), wr ? "R3 frame bits" : "R4 frame bits",
              cap_o & exp_e, exp_f & exp_e);
        check(cap_e == exp_e, wr ? "R3 drive enable" : "R4 drive release", cap_e, exp_e);
        check(r[31] == 1'b0, "R5 go self-clear", 64'(r[31]), 64'd0);
    endtask

    initial begin
        logic [31:0] r;
        int t0, t1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        bus_read(2'd0, r); check(r == 32'h8000_0000, "R1 control", r, 32'h8000_0000);
        bus_read(2'd1, r); check(r == 32'h0, "R1 command", r, 0);
        bus_read(2'd2, r); check(r == 32'h0, "R1 alive", r, 0);
        check(mdio_oe == 1'b0 && mdc == 1'b0, "R1 pins", {mdio_oe, mdc}, 0);

        // R10 control readback
        bus_write(2'd0, 32'h4004_005A);
        bus_read(2'd0, r); check(r == 32'hC004_005A, "R10 control", r, 32'hC004_005A);

        // R2 divider periods
        foreach (VEC[i]) begin end
        bus_write(2'd0, 32'h4000_0004);
        @(posedge mdc); t0 = cyc; @(posedge mdc); t1 = cyc;
        check(t1 - t0 == 5, "R2 period div4", t1 - t0, 5);
        bus_write(2'd0, 32'h4000_0000);
        @(posedge mdc); t0 = cyc; @(posedge mdc); t1 = cyc;
        check(t1 - t0 == 2, "R2 period div0", t1 - t0, 2);
        bus_write(2'd0, 32'h4000_0003);
        @(posedge mdc); t0 = cyc; @(posedge mdc); t1 = cyc;
        check(t1 - t0 == 4, "R2 period div3", t1 - t0, 4);

        // table of transactions: R3 R4 R5 R7 R8
        for (int i = 0; i < 6; i++) begin
            logic [27:0] v;
            v = VEC[i];
            run_txn(1'b1, v[27], v[26], v[25:21], v[20:16], v[15:0], 1'b0);
            if (!v[27]) begin
                check(last_cmd[29] == v[26], "R7 ack bit", 64'(last_cmd[29]), 64'(v[26]));
                check(last_cmd[15:0] == (v[26] ? v[15:0] : 16'hFFFF), "R7 read data",
                      64'(last_cmd[15:0]), 64'(v[26] ? v[15:0] : 16'hFFFF));
                if (v[26]) exp_alive[v[25:21]] = 1'b1;
            end
        end
        bus_read(2'd2, r); check(r == exp_alive, "R8 alive map", r, exp_alive);

        // R6 command write during an access is ignored
        run_txn(1'b1, 1'b0, 1'b1, 5'd3, 5'd5, 16'h5A0F, 1'b1);
        check(last_cmd[25:16] == {5'd5, 5'd3}, "R6 fields kept",
              64'(last_cmd[25:16]), 64'({5'd5, 5'd3}));
        check(last_cmd[15:0] == 16'h5A0F && last_cmd[30] == 1'b0, "R6 data kept",
              64'(last_cmd[30:0]), 64'(16'h5A0F));

        // R5 go waits while the engine is off
        bus_write(2'd0, 32'h0000_0003);
        bus_write(2'd1, {1'b1, 1'b0, 1'b0, 3'b0, 5'd7, 5'd12, 16'h0});
        repeat (40) @(posedge clk);
        bus_read(2'd0, r);
        check(r[31] == 1'b0 && mdio_oe == 1'b0, "R5 pending while off",
              {r[31], mdio_oe}, 0);
        bus_write(2'd0, 32'h4000_0003);
        run_txn(1'b0, 1'b0, 1'b1, 5'd12, 5'd7, 16'hBEEF, 1'b0);
        check(last_cmd[15:0] == 16'hBEEF, "R7 read after enable",
              64'(last_cmd[15:0]), 64'hBEEF);
        bus_read(2'd0, r); check(r[31] == 1'b1, "R5 idle after finish", 64'(r[31]), 1);
        exp_alive[12] = 1'b1;
        bus_read(2'd2, r); check(r == exp_alive, "R8 alive grows", r, exp_alive);

        // R9 fault flag
        bus_read(2'd0, r); check(r[19] == 1'b0, "R9 fault clear before", 64'(r[19]), 0);
        bus_write(2'd0, 32'h4004_0003);
        run_txn(1'b1, 1'b0, 1'b0, 5'd20, 5'd1, 16'h0, 1'b0);
        bus_read(2'd0, r); check(r[19] == 1'b1, "R9 fault set", 64'(r[19]), 1);
        bus_write(2'd0, 32'h400C_0003);
        bus_read(2'd0, r); check(r[19] == 1'b0, "R9 fault cleared", 64'(r[19]), 0);
        bus_read(2'd2, r); check(r == exp_alive, "R8 nack no alive", r, exp_alive);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule